// File: doc/BRIEF.md
# Programmable-Modulus Phase-Frequency Synthesizer Core

This block is the digital half of a clock synthesizer loop. Two input strobes stand for the edges of a reference clock and of an external tunable oscillator, both already brought into the core clock domain. Each strobe stream passes through its own divider with a programmable modulus. The two divided edge streams feed a phase-frequency detector. The detector tells the external loop filter whether to raise the oscillator frequency, lower it, or leave it alone. Once the loop settles, the oscillator runs at v/r times the reference.

The detector result stands in for a three-state pump pin. With the enable low the pin floats. With the enable high, the level says which way to steer. When both requests are briefly active together, a mid-level flag marks the short reset window that a locked loop shows once per comparison period. A small write port loads the two moduli. A new modulus reaches a divider only at that divider's next terminal count, so no runt divided pulse is ever produced.

Top module: `fsyn_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, both dividers clear their counts and return to divide-by-1. Both detector flops clear, and both modulus registers return to 1. After that edge `pump_en`, `pump_up`, `pump_dn`, `pump_mid`, `ref_div` and `osc_div` are all 0.
- R2: With a modulus of N (1 to 63), a divider raises its divided output for one cycle on every Nth input strobe. That output appears in the cycle after the edge that sampled the strobe.
- R3: A modulus value of 0 divides by 1.
- R4: A modulus written while a divider is mid-count is used only from that divider's next terminal count. The count in progress finishes with the old modulus.
- R5: A divided reference pulse with no pending oscillator request gives, one cycle later, `pump_up`=1, `pump_en`=1, `pump_lvl`=1 and `pump_mid`=0. This is the increase request.
- R6: A divided oscillator pulse with no pending reference request gives, one cycle later, `pump_dn`=1, `pump_en`=1, `pump_lvl`=0 and `pump_mid`=0. This is the decrease request.
- R7: When both requests are active, `pump_mid`=1 and `pump_en`=1 for that one cycle. Both requests then clear at the next edge, except for a request set again by a divided pulse arriving at that same edge.
- R8: A pending request stays set through further divided pulses of the same side. The detector therefore stays at one sign under a pure frequency error rather than toggling.
- R9: Divided pulses from both sides arriving at the same edge produce a single mid-level cycle followed by float.
- R10: A write with `wr_en`=1 loads `wr_data` into the reference modulus when `wr_sel`=0 and into the oscillator modulus when `wr_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| osc_tick | input | 1 | One-cycle strobe per oscillator clock edge |
| wr_en | input | 1 | Modulus write strobe |
| wr_sel | input | 1 | 0 selects the reference modulus, 1 the oscillator modulus |
| wr_data | input | MOD_W | Modulus value to write |
| ref_div | output | 1 | Divided reference pulse |
| osc_div | output | 1 | Divided oscillator pulse |
| pump_up | output | 1 | Increase request |
| pump_dn | output | 1 | Decrease request |
| pump_en | output | 1 | Pump drive enable, 0 means float |
| pump_lvl | output | 1 | Driven level: 1 raises, 0 lowers |
| pump_mid | output | 1 | Both requests active (mid-level window) |

## Verification
The hardest case to reach is a modulus write that lands in the middle of a count, especially one that lands on the very edge where the divider reaches terminal count. At that edge the old register value must still be the one loaded. The stimulus gets there by programming one modulus, streaming strobes, and issuing the rewrite a known number of strobes into the count. It also issues one rewrite on the exact terminal cycle. A reference model in the bench, built from the requirements, predicts every divided pulse and pump state for each cycle.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
   typedef enum logic [1:0] {
      PMP_FLOAT = 2'd0,
      PMP_UP    = 2'd1,
      PMP_DN    = 2'd2,
      PMP_MID   = 2'd3
   } pump_e;
endpackage

// File: rtl/fsyn_regs.sv
module fsyn_regs #(
   parameter int MOD_W   = 6,
   parameter int RST_MOD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [MOD_W-1:0] wr_data,
   output logic [MOD_W-1:0] r_mod,
   output logic [MOD_W-1:0] v_mod
);
   localparam logic [MOD_W-1:0] RST_VAL = MOD_W'(RST_MOD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_mod <= RST_VAL;
         v_mod <= RST_VAL;
      end else if (wr_en) begin
         if (wr_sel) v_mod <= wr_data;
         else        r_mod <= wr_data;
      end
   end

   a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (r_mod == $past(wr_data)));
endmodule

// File: rtl/fsyn_divider.sv
module fsyn_divider #(
   parameter int MOD_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [MOD_W-1:0] mod_in,
   output logic             div_pulse
);
   localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

   logic [MOD_W-1:0] cnt;
   logic [MOD_W-1:0] act_n;
   logic [MOD_W-1:0] eff_mod;
   logic             term;

   assign eff_mod = (mod_in == '0) ? ONE : mod_in;
   assign term    = tick && (cnt == act_n - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_n     <= ONE;
         div_pulse <= 1'b0;
      end else begin
         div_pulse <= term;
         if (term) begin
            cnt   <= '0;
            act_n <= eff_mod;
         end else if (tick) begin
            cnt   <= cnt + ONE;
         end
      end
   end

   a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < act_n);
   a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      act_n != '0);
   a_r4_mod_held_midcount: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> $stable(act_n));
endmodule

// File: rtl/fsyn_pfd.sv
module fsyn_pfd
   import fsyn_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ref_p,
   input  logic  osc_p,
   output pump_e state
);
   logic up_q, dn_q, clr;

   assign clr = up_q && dn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= ref_p || (up_q && !clr);
         dn_q <= osc_p || (dn_q && !clr);
      end
   end

   always_comb begin
      unique case ({up_q, dn_q})
         2'b10:   state = PMP_UP;
         2'b01:   state = PMP_DN;
         2'b11:   state = PMP_MID;
         default: state = PMP_FLOAT;
      endcase
   end

   a_r7_mid_single: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ref_p && !osc_p) |=> (!up_q && !dn_q));
   a_r8_up_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && !dn_q && !osc_p) |=> up_q);
   a_r8_dn_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_q && !up_q && !ref_p) |=> dn_q);
   a_r5_ref_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
      ref_p |=> up_q);
endmodule

// File: rtl/fsyn_core.sv
module fsyn_core
   import fsyn_pkg::*;
#(
   parameter int MOD_W   = 6,
   parameter int RST_MOD = 1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             osc_tick,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [MOD_W-1:0] wr_data,
   output logic             ref_div,
   output logic             osc_div,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             pump_en,
   output logic             pump_lvl,
   output logic             pump_mid
);
   localparam int MOD_MAX = (1 << MOD_W) - 1;

   generate
      if (MOD_W < 1 || MOD_W > 16) begin : g_bad_w
         $error("fsyn_core: MOD_W out of range");
      end
      if (RST_MOD < 1 || RST_MOD > MOD_MAX) begin : g_bad_rst
         $error("fsyn_core: RST_MOD does not fit MOD_W");
      end
   endgenerate

   logic [MOD_W-1:0] r_mod, v_mod;
   pump_e            pstate;
   logic [4:0]       pump_c;

   fsyn_regs #(.MOD_W(MOD_W), .RST_MOD(RST_MOD)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .r_mod(r_mod), .v_mod(v_mod)
   );

   fsyn_divider #(.MOD_W(MOD_W)) u_rdiv (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .mod_in(r_mod),
      .div_pulse(ref_div)
   );

   fsyn_divider #(.MOD_W(MOD_W)) u_vdiv (
      .clk(clk), .rst_n(rst_n), .tick(osc_tick), .mod_in(v_mod),
      .div_pulse(osc_div)
   );

   fsyn_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .ref_p(ref_div), .osc_p(osc_div),
      .state(pstate)
   );

   // {up, dn, en, lvl, mid}
   always_comb begin
      unique case (pstate)
         PMP_UP:  pump_c = 5'b10110;
         PMP_DN:  pump_c = 5'b01100;
         PMP_MID: pump_c = 5'b11101;
         default: pump_c = 5'b00000;
      endcase
   end

   generate
      if (OUT_REG) begin : g_oreg
         logic [4:0] pump_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pump_q <= '0;
            else        pump_q <= pump_c;
         end
         assign {pump_up, pump_dn, pump_en, pump_lvl, pump_mid} = pump_q;
      end else begin : g_ocomb
         assign {pump_up, pump_dn, pump_en, pump_lvl, pump_mid} = pump_c;
      end
   endgenerate

   a_r1_float_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!pump_en && !ref_div && !osc_div));
   a_r7_mid_drives: assert property (@(posedge clk) disable iff (!rst_n)
      pump_mid |-> (pump_en && pump_up && pump_dn));
   a_r6_dn_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_dn && !pump_up) |-> (pump_en && !pump_lvl));
endmodule

// File: tb/tb_fsyn_core.sv
module tb_fsyn_core;
   localparam int W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_tick = 1'b0, osc_tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic ref_div, osc_div, pump_up, pump_dn, pump_en, pump_lvl, pump_mid;

   always #2 clk = ~clk;

   fsyn_core #(.MOD_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ref_div(ref_div), .osc_div(osc_div), .pump_up(pump_up),
      .pump_dn(pump_dn), .pump_en(pump_en), .pump_lvl(pump_lvl),
      .pump_mid(pump_mid)
   );

   typedef struct {
      int         tgt;
      logic [6:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int    edges = 0;
   int    nvec = 0, nbad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // reference model state (built from the requirements)
   int   m_rcnt, m_ract, m_vcnt, m_vact, m_rreg, m_vreg;
   logic m_rp, m_vp, m_up, m_dn;

   always @(posedge clk) edges++;

   // monitor
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].tgt <= edges) begin
         item_t it;
         logic [6:0] act;
         it  = q.pop_front();
         act = {pump_up, pump_dn, pump_en, pump_lvl, pump_mid, ref_div, osc_div};
         nvec++;
         if (act !== it.exp) begin
            nbad++;
            $display("FAIL %s: {up,dn,en,lvl,mid,rdiv,odiv} got %b expected %b (edge %0d)",
                     it.tag, act, it.exp, it.tgt);
         end
      end
   end

   function automatic int eff(input int m);
      return (m == 0) ? 1 : m;
   endfunction

   task automatic push_exp();
      item_t it;
      logic  mid;
      mid = m_up & m_dn;
      it.tgt = edges + 1;
      it.exp = {m_up, m_dn, m_up | m_dn, m_up & ~m_dn, mid, m_rp, m_vp};
      it.tag = tag;
      q.push_back(it);
   endtask

   // drive one cycle; called just after a rising edge
   task automatic drv(input logic rt, input logic ot,
                      input logic we, input logic ws, input int wd);
      bit   rterm, vterm, clr;
      logic nup, ndn;
      ref_tick = rt; osc_tick = ot; wr_en = we; wr_sel = ws; wr_data = W'(wd);
      if (!rst_n) begin
         m_rcnt = 0; m_ract = 1; m_vcnt = 0; m_vact = 1;
         m_rreg = 1; m_vreg = 1;
         m_rp = 0; m_vp = 0; m_up = 0; m_dn = 0;
      end else begin
         clr = m_up & m_dn;
         nup = m_rp | (m_up & ~clr);
         ndn = m_vp | (m_dn & ~clr);
         m_up = nup; m_dn = ndn;
         rterm = rt && (m_rcnt == m_ract - 1);
         vterm = ot && (m_vcnt == m_vact - 1);
         if (rterm) begin m_rcnt = 0; m_ract = eff(m_rreg); end
         else if (rt) m_rcnt++;
         if (vterm) begin m_vcnt = 0; m_vact = eff(m_vreg); end
         else if (ot) m_vcnt++;
         m_rp = rterm; m_vp = vterm;
         if (we) begin
            if (ws) m_vreg = wd; else m_rreg = wd;
         end
      end
      push_exp();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tag = "R1";
      drv(0, 0, 0, 0, 0);
      drv(1, 1, 0, 0, 0);
      rst_n = 1'b1;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nbad++;
         nvec++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      @(posedge clk); #1;
      do_reset();
      idle(2);

      // R10 / R2: program r=3, v=3 and run locked -> mid windows (R7, R9)
      tag = "R10";
      drv(0, 0, 1, 0, 3);
      drv(0, 0, 1, 1, 3);
      tag = "R9";
      for (int i = 0; i < 20; i++) drv(1, 1, 0, 0, 0);
      idle(3);

      // R5 / R8: reference only, up must hold
      tag = "R5";
      for (int i = 0; i < 4; i++) drv(1, 0, 0, 0, 0);
      tag = "R8";
      for (int i = 0; i < 10; i++) drv(1, 0, 0, 0, 0);
      // R7: one oscillator edge closes it with a single mid cycle
      tag = "R7";
      for (int i = 0; i < 3; i++) drv(0, 1, 0, 0, 0);
      idle(4);

      // R6 / R8: oscillator only -> decrease request held
      tag = "R6";
      for (int i = 0; i < 10; i++) drv(0, 1, 0, 0, 0);
      tag = "R7";
      for (int i = 0; i < 3; i++) drv(1, 0, 0, 0, 0);
      idle(3);

      // R3: modulus 0 divides by 1
      do_reset();
      tag = "R3";
      drv(0, 0, 1, 0, 0);
      drv(0, 0, 1, 1, 0);
      for (int i = 0; i < 8; i++) drv(1, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) drv(0, 1, 0, 0, 0);
      idle(3);

      // R2: different ratios, v=5 and r=2, staggered strobes
      tag = "R2";
      drv(0, 0, 1, 1, 5);
      drv(0, 0, 1, 0, 2);
      for (int i = 0; i < 40; i++) drv(i % 2 == 0, i % 3 != 0, 0, 0, 0);
      idle(3);

      // R4: rewrite mid-count and on the terminal cycle
      do_reset();
      tag = "R4";
      drv(0, 0, 1, 0, 4);
      drv(1, 0, 0, 0, 0);      // first terminal (divide-by-1), loads 4
      drv(1, 0, 0, 0, 0);
      drv(1, 0, 1, 0, 7);      // mid-count rewrite
      drv(1, 0, 0, 0, 0);
      drv(1, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) drv(1, 0, 0, 0, 0);
      drv(1, 0, 1, 0, 2);      // rewrite on terminal strobe
      for (int i = 0; i < 12; i++) drv(1, 0, 0, 0, 0);
      tag = "R4";
      for (int i = 0; i < 6; i++) drv(0, 1, 0, 0, 0);
      idle(3);

      // R1: reset in the middle of activity returns to float
      drv(1, 0, 0, 0, 0);
      do_reset();
      idle(2);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule